// File: doc/BRIEF.md
# Slot-Table Bandwidth Arbiter

This block decides which master owns a shared high-speed system bus. One master, the processor, has a privileged half of the bus turns. Every other master gets its share from a programmable table of ownership slots. The arbiter alternates between a processor turn and a table turn. On a table turn it walks the table in ascending slot order and grants the first slot whose owner is requesting and whose slot is live on the current pass. A slot can be disabled. A slot can also be marked so that it is live only on every 2nd, 4th or 8th pass, which gives an owner a fraction of a slot.

Software fills the table through a simple write port. Writes land in a shadow copy. The shadow copy becomes the active table only when a pass over the table ends, so a pass never mixes old and new entries. A grant is held until the granted master signals that its burst is done. The arbiter never leaves the bus idle while someone eligible is waiting. If the processor does not want its turn, the table side is served. If the rest of the table holds nobody eligible, the processor is served.

The guaranteed share of a table master is its number of live slots per pass divided by the active slots, applied to the half of the bus turns that the table side owns.

Top module: `bw_slot_arbiter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `cpu_gnt` and `mst_gnt` are all zero and `slot_idx` is 0. After reset the active table and the shadow table hold only disabled entries.
- R2: At most one of `cpu_gnt` and the `mst_gnt` bits is high in any cycle.
- R3: A grant keeps its value until `xfer_done` is sampled high at a clock edge. That edge clears all grants. The next grant can appear at the following edge at the earliest, so every grant ends with at least one idle cycle.
- R4: Turns alternate. On a processor turn with `cpu_req` high, the processor is granted and the turn passes to the table. After a table grant, the turn passes to the processor.
- R5: The arbiter conserves work. If the processor is not requesting on its turn, an eligible table slot is granted. If no eligible slot remains in the current pass, the processor is granted when it requests. With no eligible requester, no grant is given.
- R6: Table slots are examined in ascending order, starting at the pass pointer. Ineligible slots are skipped within the same cycle. After a grant of slot s, the pointer moves to s+1.
- R7: A master is never granted through a disabled slot. A master that owns no enabled slot is never granted.
- R8: A master that holds k enabled full-rate slots receives k grants per pass while all masters request.
- R9: The fraction code f of a slot (0, 1, 2 or 3) makes the slot live only on passes whose count, modulo 8, is a multiple of 2^f.
- R10: A pass ends when the last slot is granted, or when an arbitration cycle finds no eligible slot from the pointer onward. At the end of a pass the pointer returns to 0, the pass count increments, and the shadow table is copied to the active table. A write made at the same edge is applied at the next pass end.
- R11: `slot_idx` shows the pass pointer, which is the next slot to be examined.
- R12: A table write places `tbl_wdata` into slot `tbl_addr` with this layout: bit [MSB] is the enable, the next FRAC_W bits are the fraction code, and the low bits are the owner master index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor bus request |
| mst_req | input | NUM_MST | Request lines of the table masters |
| xfer_done | input | 1 | The granted burst finishes at this edge |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | clog2(NUM_SLOTS) | Slot to write |
| tbl_wdata | input | 1+FRAC_W+clog2(NUM_MST) | {enable, fraction code, owner} |
| cpu_gnt | output | 1 | Processor grant |
| mst_gnt | output | NUM_MST | One-hot grant of the table masters |
| slot_idx | output | clog2(NUM_SLOTS) | Pass pointer, the next slot to examine |

## Verification
The bench exercises several corner cases. A slot owned by a master that is not requesting must be skipped in the same cycle. A design that idled there would drop grants and drift from the model. A table turn that finds nothing eligible must fall back to the processor and end the pass. If it did not, the rotation count and the shadow-table swap would come late, and fractional slots would fire on the wrong passes. The bench reprograms slots while grants are flowing and checks that the new owner appears only after the pass boundary. An early swap would grant the new owner too soon. It also runs long bursts with the processor silent and then with every slot disabled. A design that ignored `xfer_done`, or that granted a disabled slot, shows a mismatch within a few cycles.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;

  typedef enum logic {
    TURN_CPU = 1'b0,
    TURN_TBL = 1'b1
  } turn_e;

  // Pass-count mask for a fraction code: a slot is live when (pass & mask) == 0.
  function automatic int unsigned live_mask(input int unsigned code);
    return (32'd1 << code) - 32'd1;
  endfunction

endpackage

// File: rtl/slot_table.sv
// Shadow and active ownership tables; the shadow is copied at each pass end.
module slot_table #(
  parameter int NUM_SLOTS = 16,
  parameter int ENT_W     = 5,
  localparam int SLW      = $clog2(NUM_SLOTS)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [SLW-1:0]                  waddr,
  input  logic [ENT_W-1:0]                wdata,
  input  logic                            swap,
  output logic [NUM_SLOTS-1:0][ENT_W-1:0] act_tbl
);

  logic [NUM_SLOTS-1:0][ENT_W-1:0] shadow;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        shadow[s]  <= '0;
        act_tbl[s] <= '0;
      end else begin
        if (swap) act_tbl[s] <= shadow[s];
        if (we && (waddr == SLW'(s))) shadow[s] <= wdata;
      end
    end
  end

endmodule

// File: rtl/slot_scan.sv
// Finds the lowest eligible slot at or after the pass pointer in one cycle.
module slot_scan
  import slot_arb_pkg::*;
#(
  parameter int NUM_MST   = 4,
  parameter int NUM_SLOTS = 16,
  parameter int FRAC_W    = 2,
  localparam int IDW      = $clog2(NUM_MST),
  localparam int SLW      = $clog2(NUM_SLOTS),
  localparam int ENT_W    = 1 + FRAC_W + IDW,
  localparam int ROT_W    = (1 << FRAC_W) - 1
) (
  input  logic [NUM_SLOTS-1:0][ENT_W-1:0] act_tbl,
  input  logic [NUM_MST-1:0]              mst_req,
  input  logic [SLW-1:0]                  ptr,
  input  logic [ROT_W-1:0]                rot,
  output logic                            hit,
  output logic [SLW-1:0]                  sel,
  output logic [IDW-1:0]                  sel_owner
);

  logic [(1<<IDW)-1:0] req_ext;
  logic [NUM_SLOTS-1:0] elig;

  always_comb begin
    req_ext = '0;
    req_ext[NUM_MST-1:0] = mst_req;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_elig
    logic              en;
    logic [FRAC_W-1:0] frac;
    logic [IDW-1:0]    owner;
    logic              live;
    assign en    = act_tbl[s][ENT_W-1];
    assign frac  = act_tbl[s][IDW +: FRAC_W];
    assign owner = act_tbl[s][IDW-1:0];
    assign live  = ((32'(rot) & live_mask(32'(frac))) == 32'd0);
    assign elig[s] = en && req_ext[owner] && live && (SLW'(s) >= ptr);
  end

  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (elig[s]) begin
        hit = 1'b1;
        sel = SLW'(s);
      end
    end
  end

  assign sel_owner = act_tbl[sel][IDW-1:0];

endmodule

// File: rtl/bw_slot_arbiter.sv
// Alternates bus turns between the processor and a rotating slot table.
module bw_slot_arbiter
  import slot_arb_pkg::*;
#(
  parameter int NUM_MST   = 4,
  parameter int NUM_SLOTS = 16,
  parameter int FRAC_W    = 2
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     cpu_req,
  input  logic [NUM_MST-1:0]                       mst_req,
  input  logic                                     xfer_done,
  input  logic                                     tbl_we,
  input  logic [$clog2(NUM_SLOTS)-1:0]             tbl_addr,
  input  logic [FRAC_W+$clog2(NUM_MST):0]          tbl_wdata,
  output logic                                     cpu_gnt,
  output logic [NUM_MST-1:0]                       mst_gnt,
  output logic [$clog2(NUM_SLOTS)-1:0]             slot_idx
);

  localparam int IDW   = $clog2(NUM_MST);
  localparam int SLW   = $clog2(NUM_SLOTS);
  localparam int ENT_W = 1 + FRAC_W + IDW;
  localparam int ROT_W = (1 << FRAC_W) - 1;
  localparam logic [SLW-1:0] LAST_SLOT = SLW'(NUM_SLOTS - 1);

  logic [NUM_SLOTS-1:0][ENT_W-1:0] act_tbl;
  logic                            busy;
  turn_e                           turn;
  logic [SLW-1:0]                  ptr;
  logic [ROT_W-1:0]                rot;
  logic                            hit;
  logic [SLW-1:0]                  sel;
  logic [IDW-1:0]                  sel_owner;
  logic                            pick_cpu, pick_tbl, pass_end;

  slot_table #(
    .NUM_SLOTS (NUM_SLOTS),
    .ENT_W     (ENT_W)
  ) u_table (
    .clk     (clk),
    .rst     (rst),
    .we      (tbl_we),
    .waddr   (tbl_addr),
    .wdata   (tbl_wdata),
    .swap    (pass_end),
    .act_tbl (act_tbl)
  );

  slot_scan #(
    .NUM_MST   (NUM_MST),
    .NUM_SLOTS (NUM_SLOTS),
    .FRAC_W    (FRAC_W)
  ) u_scan (
    .act_tbl   (act_tbl),
    .mst_req   (mst_req),
    .ptr       (ptr),
    .rot       (rot),
    .hit       (hit),
    .sel       (sel),
    .sel_owner (sel_owner)
  );

  // Turn policy: the owner of the turn goes first, the other side takes any slack.
  always_comb begin
    pick_cpu = 1'b0;
    pick_tbl = 1'b0;
    if (!busy) begin
      if (turn == TURN_CPU) begin
        if (cpu_req)  pick_cpu = 1'b1;
        else if (hit) pick_tbl = 1'b1;
      end else begin
        if (hit)          pick_tbl = 1'b1;
        else if (cpu_req) pick_cpu = 1'b1;
      end
    end
    pass_end = !busy && (pick_tbl ? (sel == LAST_SLOT) : !hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cpu_gnt <= 1'b0;
      mst_gnt <= '0;
      turn    <= TURN_CPU;
      ptr     <= '0;
      rot     <= '0;
    end else if (busy) begin
      if (xfer_done) begin
        busy    <= 1'b0;
        cpu_gnt <= 1'b0;
        mst_gnt <= '0;
      end
    end else begin
      if (pick_cpu) begin
        busy    <= 1'b1;
        cpu_gnt <= 1'b1;
        turn    <= TURN_TBL;
      end
      if (pick_tbl) begin
        busy    <= 1'b1;
        mst_gnt <= NUM_MST'(1) << sel_owner;
        turn    <= TURN_CPU;
        ptr     <= sel + SLW'(1);
      end
      if (pass_end) begin
        ptr <= '0;
        rot <= rot + ROT_W'(1);
      end
    end
  end

  assign slot_idx = ptr;

endmodule

// File: rtl/bw_slot_arbiter_chk.sv
module bw_slot_arbiter_chk #(
  parameter int NUM_MST   = 4,
  parameter int NUM_SLOTS = 16
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         cpu_req,
  input logic [NUM_MST-1:0]           mst_req,
  input logic                         xfer_done,
  input logic                         cpu_gnt,
  input logic [NUM_MST-1:0]           mst_gnt,
  input logic [$clog2(NUM_SLOTS)-1:0] slot_idx
);

  logic [NUM_MST:0] gv;
  assign gv = {mst_gnt, cpu_gnt};

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gv));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    ((gv != '0) && !xfer_done) |=> $stable(gv));

  p_release_r3: assert property (@(posedge clk) disable iff (rst)
    ((gv != '0) && xfer_done) |=> (gv == '0));

  p_cpu_req_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_gnt) |-> $past(cpu_req));

  p_work_r5: assert property (@(posedge clk) disable iff (rst)
    ((gv == '0) && cpu_req) |=> (gv != '0));

  p_mst_req_r7: assert property (@(posedge clk) disable iff (rst)
    ((mst_gnt != '0) && ($past(mst_gnt) == '0)) |-> ((mst_gnt & $past(mst_req)) != '0));

  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> ((gv == '0) && (slot_idx == '0)));

endmodule

bind bw_slot_arbiter bw_slot_arbiter_chk #(
  .NUM_MST   (NUM_MST),
  .NUM_SLOTS (NUM_SLOTS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_req   (cpu_req),
  .mst_req   (mst_req),
  .xfer_done (xfer_done),
  .cpu_gnt   (cpu_gnt),
  .mst_gnt   (mst_gnt),
  .slot_idx  (slot_idx)
);

// File: tb/bw_slot_arbiter_bench.sv
`timescale 1ns/1ps
module bw_slot_arbiter_bench;

  localparam int NM = 4;
  localparam int NS = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_req = 1'b0;
  logic [3:0] mst_req = 4'b0;
  logic       xfer_done = 1'b0;
  logic       tbl_we = 1'b0;
  logic [3:0] tbl_addr = 4'd0;
  logic [4:0] tbl_wdata = 5'd0;
  logic       cpu_gnt;
  logic [3:0] mst_gnt;
  logic [3:0] slot_idx;

  always #2 clk = ~clk;

  bw_slot_arbiter u_bw_slot_arbiter (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .mst_req(mst_req),
    .xfer_done(xfer_done), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .cpu_gnt(cpu_gnt), .mst_gnt(mst_gnt),
    .slot_idx(slot_idx)
  );

  int checks = 0;
  int fails  = 0;
  int burst_len = 1;
  int hold_cnt = 0;
  int cnt_cpu = 0;
  int cnt_m [NM];
  logic [4:0] prev_g = 5'd0;
  logic       prev_done = 1'b0;

  // Behavioural reference model
  int m_busy, m_cpu, m_mst, m_turn, m_ptr, m_rot;
  int a_en[NS], a_fr[NS], a_ow[NS];
  int p_en[NS], p_fr[NS], p_ow[NS];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin : model
    int hit, sel;
    bit pc, pt, endp;
    if (rst) begin
      m_busy = 0; m_cpu = 0; m_mst = -1; m_turn = 0; m_ptr = 0; m_rot = 0;
      for (int s = 0; s < NS; s++) begin
        a_en[s] = 0; a_fr[s] = 0; a_ow[s] = 0;
        p_en[s] = 0; p_fr[s] = 0; p_ow[s] = 0;
      end
    end else begin
      hit = 0; sel = 0;
      for (int s = NS - 1; s >= 0; s--)
        if (s >= m_ptr && a_en[s] != 0 && mst_req[a_ow[s]] && (m_rot % (1 << a_fr[s])) == 0) begin
          hit = 1; sel = s;
        end
      if (m_busy != 0) begin
        if (xfer_done) begin m_busy = 0; m_cpu = 0; m_mst = -1; end
      end else begin
        pc = 0; pt = 0;
        if (m_turn == 0) begin
          if (cpu_req) pc = 1; else if (hit != 0) pt = 1;
        end else begin
          if (hit != 0) pt = 1; else if (cpu_req) pc = 1;
        end
        endp = pt ? (sel == NS - 1) : (hit == 0);
        if (pc) begin m_cpu = 1; m_busy = 1; m_turn = 1; end
        if (pt) begin m_mst = a_ow[sel]; m_busy = 1; m_turn = 0; m_ptr = sel + 1; end
        if (endp) begin
          m_ptr = 0; m_rot = (m_rot + 1) % 8;
          for (int s = 0; s < NS; s++) begin
            a_en[s] = p_en[s]; a_fr[s] = p_fr[s]; a_ow[s] = p_ow[s];
          end
        end
      end
      if (tbl_we) begin
        p_en[tbl_addr] = int'(tbl_wdata[4]);
        p_fr[tbl_addr] = int'(tbl_wdata[3:2]);
        p_ow[tbl_addr] = int'(tbl_wdata[1:0]);
      end
    end
  end

  // Compare, count and answer with done, away from the active edge
  always @(negedge clk) begin : cmp
    logic [4:0] g, eg;
    g = {mst_gnt, cpu_gnt};
    if (!rst) begin
      eg = {(m_mst >= 0) ? (4'b1 << m_mst) : 4'b0, m_cpu[0]};
      check(g == eg, "R4 grant vs model", int'(g), int'(eg));
      check(int'(slot_idx) == m_ptr, "R6 R11 slot pointer", int'(slot_idx), m_ptr);
      check($countones(g) <= 1, "R2 one-hot grant", int'(g), 1);
      if (prev_g != 5'd0 && !prev_done)
        check(g == prev_g, "R3 grant held", int'(g), int'(prev_g));
      if (prev_g != 5'd0 && prev_done)
        check(g == 5'd0, "R3 grant released", int'(g), 0);
      if (g != 5'd0 && prev_g == 5'd0) begin
        if (g[0]) cnt_cpu++;
        for (int i = 0; i < NM; i++) if (g[i+1]) cnt_m[i]++;
      end
    end
    prev_g = g;
    if (g != 5'd0 && !rst) begin
      if (hold_cnt >= burst_len - 1) begin xfer_done = 1'b1; hold_cnt = 0; end
      else begin xfer_done = 1'b0; hold_cnt++; end
    end else begin
      xfer_done = 1'b0; hold_cnt = 0;
    end
    prev_done = xfer_done;
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic clear_counts();
    cnt_cpu = 0;
    for (int i = 0; i < NM; i++) cnt_m[i] = 0;
  endtask

  task automatic write_slot(input int addr, input bit en, input int fr, input int ow);
    tbl_we = 1'b1;
    tbl_addr = 4'(addr);
    tbl_wdata = {en, 2'(fr), 2'(ow)};
    step(1);
    tbl_we = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", wd);
      summary();
    end
  end

  initial begin
    for (int i = 0; i < NM; i++) cnt_m[i] = 0;
    step(3);
    @(negedge clk);
    check({mst_gnt, cpu_gnt} == 5'd0, "R1 no grant in reset", int'({mst_gnt, cpu_gnt}), 0);
    check(slot_idx == 4'd0, "R1 slot_idx in reset", int'(slot_idx), 0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check({mst_gnt, cpu_gnt} == 5'd0, "R1 no grant after reset", int'({mst_gnt, cpu_gnt}), 0);
    check(slot_idx == 4'd0, "R1 R11 slot_idx after reset", int'(slot_idx), 0);
    @(posedge clk); #1;

    // R12 layout {en, frac, owner}
    write_slot(0, 1'b1, 0, 0);
    write_slot(1, 1'b1, 0, 1);
    write_slot(2, 1'b1, 0, 0);
    write_slot(4, 1'b1, 2, 2);
    write_slot(5, 1'b0, 0, 3);

    // Everyone requests, short bursts
    cpu_req = 1'b1; mst_req = 4'b1111; burst_len = 1;
    step(20);
    clear_counts();
    step(1600);
    check(cnt_m[3] == 0, "R7 unowned master", cnt_m[3], 0);
    check(cnt_m[0] >= 2*cnt_m[1]-2 && cnt_m[0] <= 2*cnt_m[1]+2, "R8 double share", cnt_m[0], 2*cnt_m[1]);
    check(cnt_m[2] >= cnt_m[1]/4-1 && cnt_m[2] <= cnt_m[1]/4+1, "R9 quarter rate", cnt_m[2], cnt_m[1]/4);
    check(cnt_cpu >= cnt_m[0]+cnt_m[1]+cnt_m[2], "R4 processor half", cnt_cpu, cnt_m[0]+cnt_m[1]+cnt_m[2]);

    // Processor silent, long bursts, some masters idle
    cpu_req = 1'b0; burst_len = 3; mst_req = 4'b0101;
    step(10);
    clear_counts();
    step(600);
    check(cnt_cpu == 0, "R5 no processor grant", cnt_cpu, 0);
    check(cnt_m[0] > 0, "R5 table served without processor", cnt_m[0], 1);
    check(cnt_m[1] == 0, "R6 idle owner skipped", cnt_m[1], 0);

    // Reprogram a slot while traffic flows
    mst_req = 4'b1111; cpu_req = 1'b1; burst_len = 2;
    step(7);
    write_slot(5, 1'b1, 0, 3);
    clear_counts();
    step(300);
    check(cnt_m[3] > 0, "R10 R12 new owner after pass end", cnt_m[3], 1);

    // Disable every slot: only the processor may win
    write_slot(0, 1'b0, 0, 0);
    write_slot(1, 1'b0, 0, 1);
    write_slot(2, 1'b0, 0, 0);
    write_slot(4, 1'b0, 2, 2);
    write_slot(5, 1'b0, 0, 3);
    step(60);
    clear_counts();
    step(400);
    check(cnt_m[0]+cnt_m[1]+cnt_m[2]+cnt_m[3] == 0, "R7 disabled slots", cnt_m[0]+cnt_m[1]+cnt_m[2]+cnt_m[3], 0);
    check(cnt_cpu > 0, "R5 processor served when table empty", cnt_cpu, 1);

    // Nobody requests
    cpu_req = 1'b0; mst_req = 4'b0;
    step(10);
    clear_counts();
    step(50);
    check(cnt_cpu == 0 && cnt_m[0] == 0, "R5 no grant without request", cnt_cpu + cnt_m[0], 0);

    summary();
  end

endmodule